// File: doc/BRIEF.md
# SDRAM Command Timing Enforcer

This block sits between an SDRAM command generator and the memory command pins. Each cycle the generator offers at most one command: activate, read, write, precharge, refresh or self-refresh exit. The block holds that request until every programmed minimum gap that applies to it has elapsed, then grants it and forwards it in the same cycle. The gap values arrive on plain configuration inputs, each four bits wide.

The block also keeps each sub-bank's page open on a timer. After a read or a write, a per-bank countdown decides when the block closes the page by itself with a precharge. While the page is still open, the block tells the generator whether the offered read or write targets the open row. In auto-precharge mode the same countdown marks the start of the memory's own precharge. No command is emitted then, and page hits are never reported.

Top module: `sdram_cmd_pacer`

## Requirements
- R1: A read (code 2) or write (code 3) to a bank is granted no sooner than eff(act_rw_gap_i) cycles after the activate (code 1) of that bank, where eff(v) is v with 0 read as 1 and the gap is loaded when the activate is granted.
- R2: An activate is granted no sooner than eff(ref_act_gap_i) cycles after a refresh (code 5).
- R3: An activate to a bank is granted no sooner than eff(pre_act_gap_i) cycles after that bank was closed. An activate to a bank that is still open is held until the bank closes.
- R4: With auto_pre_i low, a granted read loads the bank's page timer with eff(rd_pre_gap_i) and a write loads it with eff(wr_pre_gap_i). Each later read or write reloads the timer. When it runs out, the block emits a precharge (code 4) to that bank. A requested precharge cancels the timer.
- R5: page_hit_o is high only while a read or write request is valid, its bank is open, the row matches, the bank's timer has not run out and auto_pre_i is low.
- R6: With col9_i high the row compare uses address bits [ADDR_W-1:9]. With col9_i low it uses bits [ADDR_W-1:8].
- R7: With auto_pre_i high, page_hit_o stays low. When the page timer runs out, the bank closes with no command on the outputs, and the gap of R3 then applies.
- R8: After a self-refresh exit (code 6), no request is granted for eff(srx_gap_i) cycles.
- R9: Activates to two different banks are at least 2 cycles apart. This gap is fixed.
- R10: A gap field of 0 behaves exactly like a field of 1.
- R11: A timer precharge takes the command slot of its cycle, and no request is granted in that cycle. When several banks run out together, the lowest bank index goes first and the others follow in later cycles.
- R12: After reset no bank is open, all timers are clear, cmd_valid_o is low and a request is ready. A granted request appears on cmd_o/cmd_bank_o in the cycle it is granted. A no-op (code 0) is accepted without any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_rw_gap_i | input | 4 | Activate to read/write gap |
| ref_act_gap_i | input | 4 | Refresh to activate gap |
| rd_pre_gap_i | input | 4 | Read to timer precharge gap |
| wr_pre_gap_i | input | 4 | Write to timer precharge gap |
| pre_act_gap_i | input | 4 | Precharge to activate gap |
| srx_gap_i | input | 4 | Self-refresh exit hold |
| auto_pre_i | input | 1 | Auto-precharge mode |
| col9_i | input | 1 | 1: 9 column bits, 0: 8 column bits |
| req_valid_i | input | 1 | Request valid |
| req_cmd_i | input | 3 | Request command code |
| req_bank_i | input | 2 | Request bank |
| req_addr_i | input | 22 | Request linear address |
| req_ready_o | output | 1 | Request may be granted this cycle |
| page_hit_o | output | 1 | Request hits the open page |
| cmd_valid_o | output | 1 | Command issued this cycle |
| cmd_o | output | 3 | Issued command code |
| cmd_bank_o | output | 2 | Issued command bank |

## Verification
A countdown that runs slow or fast moves a grant by whole cycles. It shows on cmd_valid_o in the very cycle the held request should have gone out, so the bench compares exact grant cycles rather than just the order of commands. A wrong open/closed flag or a stale row tag shows as a wrong page_hit_o on the next read or write. It can also show as an activate held forever, or as a precharge that appears, or goes missing, a fixed number of cycles after the last access. Auto-precharge errors show as an unexpected command on the outputs, which the scoreboard catches at once.

// File: rtl/sdcp_pkg.sv
package sdcp_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_SRX = 3'd6
  } cmd_e;

  // fixed bank-to-bank activate spacing
  localparam int unsigned RRD_CYCLES = 2;
endpackage

// File: rtl/sdcp_bank.sv
module sdcp_bank #(
  parameter int unsigned TW    = 4,
  parameter int unsigned TAG_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             rdwr_i,
  input  logic             wr_sel_i,
  input  logic             close_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TW-1:0]    rcd_i,
  input  logic [TW-1:0]    pta_i,
  input  logic [TW-1:0]    rtp_i,
  input  logic [TW-1:0]    wtp_i,
  output logic             open_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             rcd_ok_o,
  output logic             pta_ok_o,
  output logic             close_due_o
);
  logic             open_q, armed_q;
  logic [TAG_W-1:0] tag_q;
  logic [TW-1:0]    rcd_q, pta_q, pc_q;

  // gap N loads N-1 so the follow-up is legal exactly N cycles later
  function automatic logic [TW-1:0] ld(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic [TW-1:0] dec(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      armed_q <= 1'b0;
      tag_q   <= '0;
      rcd_q   <= '0;
      pta_q   <= '0;
      pc_q    <= '0;
    end else begin
      rcd_q <= act_i   ? ld(rcd_i) : dec(rcd_q);
      pta_q <= close_i ? ld(pta_i) : dec(pta_q);
      if (rdwr_i)       pc_q <= ld(wr_sel_i ? wtp_i : rtp_i);
      else if (armed_q) pc_q <= dec(pc_q);
      if (act_i) begin
        open_q <= 1'b1;
        tag_q  <= tag_i;
      end
      if (rdwr_i && open_q) armed_q <= 1'b1;
      if (close_i) begin
        open_q  <= 1'b0;
        armed_q <= 1'b0;
      end
    end
  end

  assign open_o      = open_q;
  assign tag_o       = tag_q;
  assign rcd_ok_o    = (rcd_q == '0);
  assign pta_ok_o    = (pta_q == '0);
  assign close_due_o = armed_q && open_q && (pc_q == '0);
endmodule

// File: rtl/sdcp_glob.sv
module sdcp_glob #(
  parameter int unsigned TW     = 4,
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic [BANK_W-1:0] act_bank_i,
  input  logic              ref_i,
  input  logic              srx_i,
  input  logic [TW-1:0]     rfta_i,
  input  logic [TW-1:0]     srex_i,
  output logic              rfta_ok_o,
  output logic              srex_ok_o,
  output logic              rrd_busy_o,
  output logic [BANK_W-1:0] last_bank_o
);
  import sdcp_pkg::*;

  localparam int unsigned RRD_W = $clog2(RRD_CYCLES) + 1;

  logic [TW-1:0]     rfta_q, srex_q;
  logic [RRD_W-1:0]  rrd_q;
  logic [BANK_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rfta_q <= '0;
      srex_q <= '0;
      rrd_q  <= '0;
      last_q <= '0;
    end else begin
      if (ref_i)               rfta_q <= (rfta_i == '0) ? '0 : rfta_i - 1'b1;
      else if (rfta_q != '0)   rfta_q <= rfta_q - 1'b1;
      if (srx_i)               srex_q <= (srex_i == '0) ? '0 : srex_i - 1'b1;
      else if (srex_q != '0)   srex_q <= srex_q - 1'b1;
      if (act_i) begin
        rrd_q  <= RRD_W'(RRD_CYCLES - 1);
        last_q <= act_bank_i;
      end else if (rrd_q != '0) begin
        rrd_q <= rrd_q - 1'b1;
      end
    end
  end

  assign rfta_ok_o   = (rfta_q == '0);
  assign srex_ok_o   = (srex_q == '0);
  assign rrd_busy_o  = (rrd_q != '0);
  assign last_bank_o = last_q;
endmodule

// File: rtl/sdcp_arb.sv
module sdcp_arb #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned TAG_W     = 14
) (
  input  logic                            req_valid_i,
  input  logic [2:0]                      req_cmd_i,
  input  logic [BANK_W-1:0]               req_bank_i,
  input  logic [TAG_W-1:0]                req_tag_i,
  input  logic                            col9_i,
  input  logic                            auto_i,
  input  logic [NUM_BANKS-1:0]            open_i,
  input  logic [NUM_BANKS-1:0][TAG_W-1:0] tag_i,
  input  logic [NUM_BANKS-1:0]            rcd_ok_i,
  input  logic [NUM_BANKS-1:0]            pta_ok_i,
  input  logic [NUM_BANKS-1:0]            close_due_i,
  input  logic                            rfta_ok_i,
  input  logic                            srex_ok_i,
  input  logic                            rrd_busy_i,
  input  logic [BANK_W-1:0]               last_bank_i,
  output logic                            ready_o,
  output logic                            hit_o,
  output logic                            ap_fire_o,
  output logic [BANK_W-1:0]               ap_bank_o
);
  import sdcp_pkg::*;

  logic due_any, row_match, is_rdwr, cmd_ok;

  // lowest due bank wins the precharge slot
  always_comb begin
    due_any   = 1'b0;
    ap_bank_o = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (close_due_i[i]) begin
        due_any   = 1'b1;
        ap_bank_o = BANK_W'(i);
      end
    end
  end

  assign ap_fire_o = due_any && !auto_i;

  always_comb begin
    if (col9_i) row_match = (tag_i[req_bank_i][TAG_W-1:1] == req_tag_i[TAG_W-1:1]);
    else        row_match = (tag_i[req_bank_i] == req_tag_i);
  end

  assign is_rdwr = (req_cmd_i == CMD_RD) || (req_cmd_i == CMD_WR);
  assign hit_o   = req_valid_i && is_rdwr && open_i[req_bank_i] && row_match
                   && !close_due_i[req_bank_i] && !auto_i;

  always_comb begin
    unique case (req_cmd_i)
      CMD_ACT: cmd_ok = !open_i[req_bank_i] && pta_ok_i[req_bank_i]
                        && !close_due_i[req_bank_i] && rfta_ok_i
                        && !(rrd_busy_i && (last_bank_i != req_bank_i));
      CMD_RD,
      CMD_WR:  cmd_ok = rcd_ok_i[req_bank_i];
      default: cmd_ok = 1'b1;
    endcase
  end

  assign ready_o = cmd_ok && srex_ok_i && !ap_fire_o;
endmodule

// File: rtl/sdram_cmd_pacer.sv
module sdram_cmd_pacer #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned TW        = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [TW-1:0]                act_rw_gap_i,
  input  logic [TW-1:0]                ref_act_gap_i,
  input  logic [TW-1:0]                rd_pre_gap_i,
  input  logic [TW-1:0]                wr_pre_gap_i,
  input  logic [TW-1:0]                pre_act_gap_i,
  input  logic [TW-1:0]                srx_gap_i,
  input  logic                         auto_pre_i,
  input  logic                         col9_i,
  input  logic                         req_valid_i,
  input  logic [2:0]                   req_cmd_i,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank_i,
  input  logic [ADDR_W-1:0]            req_addr_i,
  output logic                         req_ready_o,
  output logic                         page_hit_o,
  output logic                         cmd_valid_o,
  output logic [2:0]                   cmd_o,
  output logic [$clog2(NUM_BANKS)-1:0] cmd_bank_o
);
  import sdcp_pkg::*;

  localparam int unsigned BANK_W = $clog2(NUM_BANKS);
  localparam int unsigned TAG_W  = ADDR_W - 8;
  localparam int unsigned AGE_W  = TW + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(1 << TW);

  logic [TAG_W-1:0]                req_tag;
  logic [NUM_BANKS-1:0]            open_v, rcd_ok_v, pta_ok_v, due_v, close_v;
  logic [NUM_BANKS-1:0][TAG_W-1:0] tag_v;
  logic                            rfta_ok, srex_ok, rrd_busy, ap_fire, ready, gnt;
  logic [BANK_W-1:0]               last_bank, ap_bank;
  logic                            g_act, g_rdwr, g_pre, g_ref, g_srx;

  assign req_tag = req_addr_i[ADDR_W-1:8];
  assign gnt     = req_valid_i && ready;
  assign g_act   = gnt && (req_cmd_i == CMD_ACT);
  assign g_rdwr  = gnt && ((req_cmd_i == CMD_RD) || (req_cmd_i == CMD_WR));
  assign g_pre   = gnt && (req_cmd_i == CMD_PRE);
  assign g_ref   = gnt && (req_cmd_i == CMD_REF);
  assign g_srx   = gnt && (req_cmd_i == CMD_SRX);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (req_bank_i == BANK_W'(b));
    // closed by request, by timer precharge, or silently in auto mode
    assign close_v[b] = (g_pre && sel) || (ap_fire && (ap_bank == BANK_W'(b)))
                        || (auto_pre_i && due_v[b]);
    sdcp_bank #(.TW(TW), .TAG_W(TAG_W)) i_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .act_i       (g_act && sel),
      .rdwr_i      (g_rdwr && sel),
      .wr_sel_i    (req_cmd_i == CMD_WR),
      .close_i     (close_v[b]),
      .tag_i       (req_tag),
      .rcd_i       (act_rw_gap_i),
      .pta_i       (pre_act_gap_i),
      .rtp_i       (rd_pre_gap_i),
      .wtp_i       (wr_pre_gap_i),
      .open_o      (open_v[b]),
      .tag_o       (tag_v[b]),
      .rcd_ok_o    (rcd_ok_v[b]),
      .pta_ok_o    (pta_ok_v[b]),
      .close_due_o (due_v[b])
    );
  end

  sdcp_glob #(.TW(TW), .BANK_W(BANK_W)) i_glob (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (g_act),
    .act_bank_i  (req_bank_i),
    .ref_i       (g_ref),
    .srx_i       (g_srx),
    .rfta_i      (ref_act_gap_i),
    .srex_i      (srx_gap_i),
    .rfta_ok_o   (rfta_ok),
    .srex_ok_o   (srex_ok),
    .rrd_busy_o  (rrd_busy),
    .last_bank_o (last_bank)
  );

  sdcp_arb #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .TAG_W(TAG_W)) i_arb (
    .req_valid_i (req_valid_i),
    .req_cmd_i   (req_cmd_i),
    .req_bank_i  (req_bank_i),
    .req_tag_i   (req_tag),
    .col9_i      (col9_i),
    .auto_i      (auto_pre_i),
    .open_i      (open_v),
    .tag_i       (tag_v),
    .rcd_ok_i    (rcd_ok_v),
    .pta_ok_i    (pta_ok_v),
    .close_due_i (due_v),
    .rfta_ok_i   (rfta_ok),
    .srex_ok_i   (srex_ok),
    .rrd_busy_i  (rrd_busy),
    .last_bank_i (last_bank),
    .ready_o     (ready),
    .hit_o       (page_hit_o),
    .ap_fire_o   (ap_fire),
    .ap_bank_o   (ap_bank)
  );

  assign req_ready_o = ready;
  assign cmd_valid_o = ap_fire || (gnt && (req_cmd_i != CMD_NOP));
  assign cmd_o       = ap_fire ? CMD_PRE : (cmd_valid_o ? req_cmd_i : CMD_NOP);
  assign cmd_bank_o  = ap_fire ? ap_bank : (cmd_valid_o ? req_bank_i : '0);

  // ---- independent gap monitors for the assertions ----
  function automatic logic [AGE_W-1:0] eff(input logic [TW-1:0] v);
    return (v == '0) ? AGE_W'(1) : AGE_W'(v);
  endfunction

  logic [AGE_W-1:0]  ref_age, ref_need, srx_age, srx_need, any_act_age;
  logic [BANK_W-1:0] chk_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_age <= AGE_MAX; ref_need <= AGE_W'(1);
      srx_age <= AGE_MAX; srx_need <= AGE_W'(1);
      any_act_age <= AGE_MAX; chk_last <= '0;
    end else begin
      if (g_ref) begin ref_age <= AGE_W'(1); ref_need <= eff(ref_act_gap_i); end
      else if (ref_age != AGE_MAX) ref_age <= ref_age + 1'b1;
      if (g_srx) begin srx_age <= AGE_W'(1); srx_need <= eff(srx_gap_i); end
      else if (srx_age != AGE_MAX) srx_age <= srx_age + 1'b1;
      if (g_act) begin any_act_age <= AGE_W'(1); chk_last <= req_bank_i; end
      else if (any_act_age != AGE_MAX) any_act_age <= any_act_age + 1'b1;
    end
  end

  a_r2_ref_to_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g_act |-> (ref_age >= ref_need));
  a_r8_srx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt && (req_cmd_i != CMD_NOP)) |-> (srx_age >= srx_need));
  a_r9_bank_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g_act && (req_bank_i != chk_last)) |-> (any_act_age >= AGE_W'(RRD_CYCLES)));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    logic [AGE_W-1:0] act_age, act_need, cls_age, cls_need;
    logic             hit_b;
    assign hit_b = (req_bank_i == BANK_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_age <= AGE_MAX; act_need <= AGE_W'(1);
        cls_age <= AGE_MAX; cls_need <= AGE_W'(1);
      end else begin
        if (g_act && hit_b) begin act_age <= AGE_W'(1); act_need <= eff(act_rw_gap_i); end
        else if (act_age != AGE_MAX) act_age <= act_age + 1'b1;
        if (close_v[b]) begin cls_age <= AGE_W'(1); cls_need <= eff(pre_act_gap_i); end
        else if (cls_age != AGE_MAX) cls_age <= cls_age + 1'b1;
      end
    end
    a_r1_act_to_rw: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (g_rdwr && hit_b) |-> (act_age >= act_need));
    a_r3_close_to_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (g_act && hit_b) |-> (cls_age >= cls_need));
  end
endmodule

// File: tb/test_sdram_cmd_pacer.sv
module test_sdram_cmd_pacer;
  localparam int TCLK   = 10;
  localparam int ADDR_W = 22;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                         C_WR = 3'd3, C_PRE = 3'd4, C_REF = 3'd5, C_SRX = 3'd6;
  localparam logic [ADDR_W-1:0] ROW_A = 22'h12_3400;
  localparam logic [ADDR_W-1:0] ROW_X = 22'h05_6700;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] rcd = 4'd3, rfta = 4'd4, rtp = 4'd5, wtp = 4'd6, pta = 4'd2, srex = 4'd7;
  logic auto_pre = 1'b0, col9 = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_cmd = 3'd0;
  logic [1:0] req_bank = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, page_hit, cmd_valid;
  logic [2:0] cmd;
  logic [1:0] cmd_bank;

  int cyc = 0, n_vec = 0, n_err = 0;
  bit done = 1'b0;

  typedef struct { int cy; logic [2:0] c; int bk; string tag; } exp_t;
  exp_t q[$];

  sdram_cmd_pacer #(.NUM_BANKS(4), .ADDR_W(ADDR_W), .TW(4)) i_sdram_cmd_pacer (
    .clk_i(clk), .rst_ni(rst_n),
    .act_rw_gap_i(rcd), .ref_act_gap_i(rfta), .rd_pre_gap_i(rtp),
    .wr_pre_gap_i(wtp), .pre_act_gap_i(pta), .srx_gap_i(srex),
    .auto_pre_i(auto_pre), .col9_i(col9),
    .req_valid_i(req_valid), .req_cmd_i(req_cmd), .req_bank_i(req_bank),
    .req_addr_i(req_addr), .req_ready_o(req_ready), .page_hit_o(page_hit),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_bank_o(cmd_bank)
  );

  always #(TCLK/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void expect_cmd(int cy, logic [2:0] c, int bk, string tag);
    exp_t e;
    e.cy = cy; e.c = c; e.bk = bk; e.tag = tag;
    q.push_back(e);
  endfunction

  // monitor: pops the scoreboard whenever a command leaves the block
  initial begin
    forever begin
      @(negedge clk); #(TCLK/4);
      if (rst_n && cmd_valid) begin
        n_vec++;
        if (q.size() == 0) begin
          n_err++;
          $display("FAIL unexpected cmd: got cyc=%0d cmd=%0d bank=%0d, expected none", cyc, cmd, cmd_bank);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.cy != cyc || e.c != cmd || e.bk != int'(cmd_bank)) begin
            n_err++;
            $display("FAIL %s: got cyc=%0d cmd=%0d bank=%0d, expected cyc=%0d cmd=%0d bank=%0d",
                     e.tag, cyc, cmd, cmd_bank, e.cy, e.c, e.bk);
          end
        end
      end
    end
  end

  task automatic drive(input logic [2:0] c, input int bk, input logic [ADDR_W-1:0] a,
                       input int exp_hit, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_bank = 2'(bk); req_addr = a;
    forever begin
      #(TCLK/4);
      if (req_ready) begin
        if (exp_hit >= 0) begin
          n_vec++;
          if (page_hit !== exp_hit[0]) begin
            n_err++;
            $display("FAIL %s page_hit: got %0b, expected %0b", tag, page_hit, exp_hit[0]);
          end
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_bit(input logic got, input logic want, input string what);
    n_vec++;
    if (got !== want) begin
      n_err++;
      $display("FAIL %s: got %0b, expected %0b", what, got, want);
    end
  endtask

  initial begin
    #(TCLK * 20000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    int b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #(TCLK/4);
    // R12: reset state
    check_bit(cmd_valid, 1'b0, "R12 idle cmd_valid");
    req_cmd = C_ACT; req_bank = 2'd0; #1;
    check_bit(req_ready, 1'b1, "R12 act ready after reset");
    check_bit(page_hit, 1'b0, "R12 page_hit after reset");
    req_cmd = C_NOP;

    // non-auto, 9 column bits
    @(negedge clk); b = cyc;
    expect_cmd(b+1, C_ACT, 0, "R12 act");
    drive(C_ACT, 0, ROW_A, -1, "R12");
    expect_cmd(b+4, C_RD, 0, "R1 rcd");
    drive(C_RD, 0, ROW_A, 1, "R1");
    expect_cmd(b+5, C_RD, 0, "R5 hit rd");
    drive(C_RD, 0, ROW_A, 1, "R5");
    expect_cmd(b+6, C_RD, 0, "R6 col9 bit8 ignored");
    drive(C_RD, 0, ROW_A | 22'h100, 1, "R6");
    expect_cmd(b+7, C_WR, 0, "R5 miss wr");
    drive(C_WR, 0, ROW_A | 22'h200, 0, "R5");
    expect_cmd(b+13, C_PRE, 0, "R4 wtp precharge");
    expect_cmd(b+15, C_ACT, 0, "R3 pta after timer pre");
    drive(C_ACT, 0, ROW_A, -1, "R3");
    expect_cmd(b+17, C_ACT, 1, "R9 rrd");
    drive(C_ACT, 1, ROW_A, -1, "R9");
    expect_cmd(b+18, C_REF, 0, "R2 ref");
    drive(C_REF, 0, '0, -1, "R2");
    expect_cmd(b+22, C_ACT, 2, "R2 rfta");
    drive(C_ACT, 2, ROW_X, -1, "R2");
    expect_cmd(b+23, C_SRX, 0, "R8 srx");
    drive(C_SRX, 0, '0, -1, "R8");
    expect_cmd(b+30, C_RD, 2, "R8 srex hold");
    drive(C_RD, 2, ROW_X, -1, "R8");
    expect_cmd(b+35, C_PRE, 2, "R4 rtp precharge");
    repeat (10) @(posedge clk);

    // auto-precharge mode
    auto_pre = 1'b1;
    @(negedge clk); b = cyc;
    expect_cmd(b+1, C_ACT, 3, "R7 act");
    drive(C_ACT, 3, ROW_X, -1, "R7");
    expect_cmd(b+4, C_RD, 3, "R7 rd no hit");
    drive(C_RD, 3, ROW_X, 0, "R7");
    expect_cmd(b+11, C_ACT, 3, "R7 silent close then pta");
    drive(C_ACT, 3, ROW_X, -1, "R7");

    // non-auto, 8 column bits
    auto_pre = 1'b0; col9 = 1'b0;
    expect_cmd(b+14, C_RD, 3, "R6 col8 same row");
    drive(C_RD, 3, ROW_X, 1, "R6");
    expect_cmd(b+15, C_RD, 3, "R6 col8 bit8 differs");
    drive(C_RD, 3, ROW_X ^ 22'h100, 0, "R6");
    expect_cmd(b+20, C_PRE, 3, "R4 rearmed precharge");
    repeat (8) @(posedge clk);

    // zero fields behave as one
    rcd = 4'd0; pta = 4'd0;
    @(negedge clk); b = cyc;
    expect_cmd(b+1, C_ACT, 3, "R10 act");
    drive(C_ACT, 3, ROW_X, -1, "R10");
    expect_cmd(b+2, C_RD, 3, "R10 rcd zero");
    drive(C_RD, 3, ROW_X, -1, "R10");
    expect_cmd(b+3, C_PRE, 3, "R4 requested pre");
    drive(C_PRE, 3, '0, -1, "R4");
    expect_cmd(b+4, C_ACT, 3, "R10 pta zero");
    drive(C_ACT, 3, ROW_X, -1, "R10");
    repeat (12) @(posedge clk);

    // two banks run out together: lowest first
    rtp = 4'd3;
    @(negedge clk); b = cyc;
    expect_cmd(b+1, C_RD, 1, "R11 rd b1");
    drive(C_RD, 1, ROW_A, -1, "R11");
    rtp = 4'd2;
    expect_cmd(b+2, C_RD, 0, "R11 rd b0");
    drive(C_RD, 0, ROW_A, -1, "R11");
    expect_cmd(b+4, C_PRE, 0, "R11 lowest first");
    expect_cmd(b+5, C_PRE, 1, "R11 second");
    repeat (10) @(posedge clk);

    while (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++; n_err++;
      $display("FAIL %s: got no cmd, expected cyc=%0d cmd=%0d bank=%0d", e.tag, e.cy, e.c, e.bk);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule